// File: doc/BRIEF.md
# Early/Late Phase-Step Digital PLL

This block closes a second-order digital control loop for a board that has to follow a remote master's timebase. Each time a master timestamp arrives, logic outside the block compares it with the local counter and presents a one-bit decision: the local side is early, or it is late. The block scales that decision, passes it through a proportional path and a saturating integral path, and feeds the sum into a signed phase accumulator.

Whenever the accumulator crosses its positive threshold it queues one "advance" step. Whenever it crosses the negative threshold it queues one "retard" step. The steps go out one at a time to the fine phase-shift port of a clock manager. That port takes a single-cycle enable with a direction bit and answers with a done pulse. Stepping this way turns the clock manager into a frequency-modulated oscillator, so the recovered clock (nominally about 5 MHz) tracks the master in frequency.

The decision input is a plain strobe with no back-pressure. The block takes one decision in every cycle in which the strobe is high and never stalls the source. The step output is a request/done handshake: at most one step is outstanding, and steps that wait are held in order in a small queue.

Top module: `phase_step_dpll`

## Requirements
- R1: A decision is sampled only when `dec_valid` is 1. `dec_late`=1 with `dec_early`=0 counts as +1, and `dec_early`=1 with `dec_late`=0 counts as -1. Both high, both low, or `dec_valid` low counts as 0 and leaves the loop state untouched.
- R2: The proportional path adds (decision × 2^MAG_LOG) >>> `kp_shift` to the accumulator in the cycle the decision is taken. With the defaults (MAG_LOG=16, threshold 2^22), `kp_shift`=0 and the integrator pinned at 0, exactly 64 late decisions from reset produce one step.
- R3: The integral path adds (decision × 2^MAG_LOG) >>> `ki_shift` to the integrator on each decision. The integrator value is added to the accumulator on every clock cycle, so a constant integrator I gives one step per 2^22 / |I| cycles.
- R4: The integrator saturates at `int_min` and `int_max` (signed) and never wraps.
- R5: When the accumulator reaches +2^(ACC_W-2) or above, 2^(ACC_W-2) is subtracted and an advance step (`ps_inc`=1) is queued.
- R6: When the accumulator reaches -2^(ACC_W-2) or below, 2^(ACC_W-2) is added and a retard step (`ps_inc`=0) is queued.
- R7: A step is issued as a one-cycle `ps_en` pulse with `ps_inc` valid in the same cycle. No further `ps_en` is issued until `ps_done` has been seen. A `ps_done` that arrives while no step is outstanding has no effect.
- R8: Steps that wait are issued in the order they arose. Up to QDEPTH of them are held (default 4), and a step that arises while the queue is full is dropped.
- R9: Synchronous reset (`rst`=1) clears the integrator, the accumulator, the queue and any outstanding step, and holds `ps_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | Decision strobe |
| dec_early | input | 1 | Local timebase ahead of master |
| dec_late | input | 1 | Local timebase behind master |
| kp_shift | input | SHW (5) | Proportional right-shift amount |
| ki_shift | input | SHW (5) | Integral right-shift amount |
| int_min | input | INT_W (20) | Signed lower limit of the integrator |
| int_max | input | INT_W (20) | Signed upper limit of the integrator |
| ps_done | input | 1 | Clock manager reports the step is complete |
| ps_en | output | 1 | One-cycle phase-step request |
| ps_inc | output | 1 | Step direction: 1 advance, 0 retard |

## Verification
The assertions take for granted that the configuration holds still while the loop runs, and that `int_min` ≤ 0 ≤ `int_max`. They also assume the integrator limits keep each per-cycle accumulator increment below the threshold, so at most one crossing happens per cycle. The bench changes gains and limits only while reset is held, and uses limits inside the 20-bit range. Its clock-manager model answers each `ps_en` with exactly one `ps_done`, two cycles later, unless a test deliberately holds it back. The one exception is a single unsolicited `ps_done`, sent while the block is idle, to show that it is ignored.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

  typedef logic signed [1:0] err_t;

  typedef enum logic {
    ISS_IDLE,
    ISS_WAIT
  } iss_state_e;

  // R1: early/late strobe mapped to a signed unit decision
  function automatic err_t map_decision(input logic valid, input logic early,
                                        input logic late);
    err_t r;
    r = 2'sd0;
    if (valid && late && !early)      r = 2'sd1;
    else if (valid && early && !late) r = -2'sd1;
    return r;
  endfunction

endpackage

// File: rtl/dpll_loop_filter.sv
module dpll_loop_filter
  import dpll_pkg::*;
#(
  parameter int INT_W   = 20,
  parameter int ACC_W   = 24,
  parameter int MAG_LOG = 16,
  parameter int SHW     = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  err_t                    err,
  input  logic [SHW-1:0]          kp_shift,
  input  logic [SHW-1:0]          ki_shift,
  input  logic signed [INT_W-1:0] int_min,
  input  logic signed [INT_W-1:0] int_max,
  output logic signed [ACC_W-1:0] prop_term,
  output logic signed [INT_W-1:0] integ_q
);

  localparam int EXT = ACC_W + 1 - INT_W;

  logic signed [ACC_W-1:0] unit_v, iinc;
  logic signed [ACC_W:0]   isum, lo_x, hi_x, nxt;

  always_comb begin
    unit_v    = {{(ACC_W-2){err[1]}}, err} <<< MAG_LOG;
    prop_term = unit_v >>> kp_shift;
    iinc      = unit_v >>> ki_shift;
    isum      = {{EXT{integ_q[INT_W-1]}}, integ_q} + {iinc[ACC_W-1], iinc};
    lo_x      = {{EXT{int_min[INT_W-1]}}, int_min};
    hi_x      = {{EXT{int_max[INT_W-1]}}, int_max};
    if (isum > hi_x)      nxt = hi_x;
    else if (isum < lo_x) nxt = lo_x;
    else                  nxt = isum;
  end

  always_ff @(posedge clk) begin
    if (rst) integ_q <= '0;
    else     integ_q <= nxt[INT_W-1:0];
  end

  // R4: with fixed limits, the integrator never leaves them
  assert_int_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    ($stable(int_min) && $stable(int_max)) |-> (integ_q >= int_min && integ_q <= int_max));

  // R1: a zero decision leaves the integrator alone
  assert_zero_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (err == 2'sd0 && integ_q >= int_min && integ_q <= int_max) |=> $stable(integ_q));

endmodule

// File: rtl/dpll_phase_acc.sv
module dpll_phase_acc #(
  parameter int INT_W = 20,
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ACC_W-1:0] prop_term,
  input  logic signed [INT_W-1:0] integ,
  output logic                    push,
  output logic                    push_inc
);

  localparam int THR = ACC_W - 2;
  localparam int EXT = ACC_W + 1 - INT_W;
  localparam logic signed [ACC_W:0] LIM = (ACC_W+1)'(1) <<< THR;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W:0]   inc_w, sum, acc_x;

  always_comb begin
    inc_w = {prop_term[ACC_W-1], prop_term} + {{EXT{integ[INT_W-1]}}, integ};
    sum   = {acc_q[ACC_W-1], acc_q} + inc_w;
    acc_x = {acc_q[ACC_W-1], acc_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      push     <= 1'b0;
      push_inc <= 1'b0;
    end else if (sum >= LIM) begin
      acc_q    <= ACC_W'(sum - LIM);  // R5
      push     <= 1'b1;
      push_inc <= 1'b1;
    end else if (sum <= -LIM) begin
      acc_q    <= ACC_W'(sum + LIM);  // R6
      push     <= 1'b1;
      push_inc <= 1'b0;
    end else begin
      acc_q    <= sum[ACC_W-1:0];
      push     <= 1'b0;
    end
  end

  // R5/R6: after each wrap, the residue stays strictly inside the thresholds
  assert_acc_range_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_x < LIM) && (acc_x > -LIM));

  // R6: a retard push only follows a non-positive residue
  assert_dec_sign_R6: assert property (@(posedge clk) disable iff (rst)
    (push && !push_inc) |-> (acc_x <= 0));

endmodule

// File: rtl/dpll_step_issuer.sv
module dpll_step_issuer
  import dpll_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic push_inc,
  input  logic ps_done,
  output logic ps_en,
  output logic ps_inc
);

  localparam int QAW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int QCW = $clog2(QDEPTH + 1);

  logic [QDEPTH-1:0] dir_q;
  logic [QAW-1:0]    rd_q, wr_q;
  logic [QCW-1:0]    cnt_q;
  iss_state_e        st_q;
  logic              pop, wr_ok;

  function automatic logic [QAW-1:0] nxt_ptr(input logic [QAW-1:0] p);
    return (p == QAW'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    pop   = (st_q == ISS_IDLE) && (cnt_q != '0);
    wr_ok = push && ((cnt_q != QCW'(QDEPTH)) || pop);  // R8: drop when full
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      dir_q <= '0;
    end else begin
      if (wr_ok) begin
        dir_q[wr_q] <= push_inc;
        wr_q        <= nxt_ptr(wr_q);
      end
      if (pop) rd_q <= nxt_ptr(rd_q);
      case ({wr_ok, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ISS_IDLE;
      ps_en  <= 1'b0;
      ps_inc <= 1'b0;
    end else begin
      ps_en <= 1'b0;
      case (st_q)
        ISS_IDLE: if (pop) begin
          ps_en  <= 1'b1;
          ps_inc <= dir_q[rd_q];
          st_q   <= ISS_WAIT;
        end
        ISS_WAIT: if (ps_done) st_q <= ISS_IDLE;  // R7
        default:  st_q <= ISS_IDLE;
      endcase
    end
  end

  // R7: nothing new while a step is outstanding
  assert_no_issue_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ISS_WAIT && !ps_done) |=> !ps_en);

  // R7: the request is a single-cycle pulse
  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    ps_en |=> !ps_en);

  // R8: occupancy bounded; an issue always consumed a held entry
  assert_depth_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= QCW'(QDEPTH));
  assert_issue_src_R8: assert property (@(posedge clk) disable iff (rst)
    ps_en |-> $past(cnt_q != '0));

  // R9: reset leaves nothing queued and no request
  assert_reset_R9: assert property (@(posedge clk)
    $past(rst) |-> (!ps_en && cnt_q == '0));

endmodule

// File: rtl/phase_step_dpll.sv
module phase_step_dpll
  import dpll_pkg::*;
#(
  parameter int INT_W   = 20,
  parameter int ACC_W   = 24,
  parameter int MAG_LOG = 16,
  parameter int SHW     = 5,
  parameter int QDEPTH  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    dec_valid,
  input  logic                    dec_early,
  input  logic                    dec_late,
  input  logic [SHW-1:0]          kp_shift,
  input  logic [SHW-1:0]          ki_shift,
  input  logic signed [INT_W-1:0] int_min,
  input  logic signed [INT_W-1:0] int_max,
  input  logic                    ps_done,
  output logic                    ps_en,
  output logic                    ps_inc
);

  err_t                    err;
  logic signed [ACC_W-1:0] prop_term;
  logic signed [INT_W-1:0] integ;
  logic                    push, push_inc;

  assign err = map_decision(dec_valid, dec_early, dec_late);

  dpll_loop_filter #(.INT_W(INT_W), .ACC_W(ACC_W), .MAG_LOG(MAG_LOG), .SHW(SHW)) u_filt (
    .clk(clk), .rst(rst), .err(err), .kp_shift(kp_shift), .ki_shift(ki_shift),
    .int_min(int_min), .int_max(int_max), .prop_term(prop_term), .integ_q(integ)
  );

  dpll_phase_acc #(.INT_W(INT_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .prop_term(prop_term), .integ(integ),
    .push(push), .push_inc(push_inc)
  );

  dpll_step_issuer #(.QDEPTH(QDEPTH)) u_iss (
    .clk(clk), .rst(rst), .push(push), .push_inc(push_inc), .ps_done(ps_done),
    .ps_en(ps_en), .ps_inc(ps_inc)
  );

endmodule

// File: tb/sim_phase_step_dpll.sv
module sim_phase_step_dpll;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dec_valid = 1'b0, dec_early = 1'b0, dec_late = 1'b0;
  logic [4:0] kp_shift = '0, ki_shift = '0;
  logic signed [19:0] int_min = '0, int_max = '0;
  logic ps_en, ps_inc, ps_done;
  logic stub_done = 1'b0, spur_done = 1'b0, hold = 1'b0;

  int n_chk = 0, n_fail = 0;
  int log_n = 0;
  bit step_log [0:511];
  bit pend = 1'b0;
  int tmr = 0;

  always #10 clk = ~clk;

  assign ps_done = stub_done | spur_done;

  phase_step_dpll u0 (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_early(dec_early),
    .dec_late(dec_late), .kp_shift(kp_shift), .ki_shift(ki_shift),
    .int_min(int_min), .int_max(int_max), .ps_done(ps_done),
    .ps_en(ps_en), .ps_inc(ps_inc)
  );

  // clock-manager stub: one done pulse two cycles after each request, unless held
  always @(negedge clk) begin
    stub_done <= 1'b0;
    if (rst) begin
      pend = 1'b0;
      tmr  = 0;
    end else if (ps_en) begin
      if (log_n < 512) step_log[log_n] = ps_inc;
      log_n = log_n + 1;
      pend  = 1'b1;
      tmr   = 1;
    end else if (pend) begin
      if (tmr > 0) tmr = tmr - 1;
      else if (!hold) begin
        stub_done <= 1'b1;
        pend = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input int kp, input int ki, input int lo, input int hi);
    @(negedge clk);
    rst = 1'b1; hold = 1'b0;
    kp_shift = 5'(kp); ki_shift = 5'(ki);
    int_min = 20'(lo); int_max = 20'(hi);
    cyc(3);
    rst = 1'b0;
    log_n = 0;
  endtask

  task automatic drive(input bit v, input bit e, input bit l, input int n);
    for (int i = 0; i < n; i++) begin
      dec_valid = v; dec_early = e; dec_late = l;
      @(negedge clk);
    end
    dec_valid = 1'b0; dec_early = 1'b0; dec_late = 1'b0;
  endtask

  task automatic t_reset_state;
    do_reset(0, 0, 0, 0);
    chk(ps_en == 1'b0, "R9 ps_en low after reset", ps_en, 0);
    cyc(20);
    chk(log_n == 0, "R9 no steps from idle reset state", log_n, 0);
  endtask

  task automatic t_prop_late;
    do_reset(0, 0, 0, 0);
    drive(1, 0, 1, 63); cyc(6);
    chk(log_n == 0, "R2 63 late decisions below threshold", log_n, 0);
    drive(1, 0, 1, 1); cyc(6);
    chk(log_n == 1, "R5 64th late decision gives one step", log_n, 1);
    chk(step_log[0] == 1'b1, "R5 overflow step is advance", step_log[0], 1);
  endtask

  task automatic t_prop_early;
    do_reset(0, 0, 0, 0);
    drive(1, 1, 0, 64); cyc(6);
    chk(log_n == 1, "R6 64 early decisions give one step", log_n, 1);
    chk(step_log[0] == 1'b0, "R6 underflow step is retard", step_log[0], 0);
  endtask

  task automatic t_no_decision;
    do_reset(0, 0, 0, 0);
    drive(1, 0, 1, 63);
    drive(1, 1, 1, 40);
    drive(0, 0, 1, 40);
    drive(1, 0, 0, 40);
    drive(0, 1, 0, 40);
    cyc(6);
    chk(log_n == 0, "R1 zero decisions leave accumulator", log_n, 0);
    drive(1, 0, 1, 1); cyc(6);
    chk(log_n == 1, "R1 one more late completes step", log_n, 1);
  endtask

  task automatic t_integral_rate;
    int base;
    do_reset(31, 4, -524288, 524287);
    drive(1, 0, 1, 16); cyc(20);
    base = log_n;
    cyc(6400);
    chk((log_n - base) >= 99 && (log_n - base) <= 101,
        "R3 integrator 2^16 gives one step per 64 cycles", log_n - base, 100);
    chk(step_log[base] == 1'b1, "R3 integral steps are advance", step_log[base], 1);
  endtask

  task automatic t_saturation;
    int base, bad;
    do_reset(31, 0, -262144, 262144);
    drive(1, 0, 1, 10); cyc(20);
    base = log_n;
    cyc(1600);
    chk((log_n - base) >= 99 && (log_n - base) <= 101,
        "R4 integrator clamps at int_max", log_n - base, 100);
    bad = 0;
    for (int i = base; i < log_n && i < 512; i++) if (!step_log[i]) bad++;
    chk(bad == 0, "R4 no wrap to negative", bad, 0);
    do_reset(31, 0, -262144, 262144);
    drive(1, 1, 0, 10); cyc(20);
    base = log_n;
    cyc(1600);
    chk((log_n - base) >= 99 && (log_n - base) <= 101,
        "R4 integrator clamps at int_min", log_n - base, 100);
    bad = 0;
    for (int i = base; i < log_n && i < 512; i++) if (step_log[i]) bad++;
    chk(bad == 0, "R4 no wrap to positive", bad, 0);
  endtask

  task automatic t_handshake;
    do_reset(0, 0, 0, 0);
    spur_done = 1'b1; cyc(1); spur_done = 1'b0;
    hold = 1'b1;
    drive(1, 0, 1, 128); cyc(20);
    chk(log_n == 1, "R7 one outstanding step while done withheld", log_n, 1);
    hold = 1'b0; cyc(20);
    chk(log_n == 2, "R7 next step follows done", log_n, 2);
  endtask

  task automatic t_order;
    do_reset(0, 0, 0, 0);
    hold = 1'b1;
    drive(1, 0, 1, 64);
    drive(1, 1, 0, 64);
    drive(1, 0, 1, 64);
    cyc(10);
    chk(log_n == 1, "R8 only first issued while held", log_n, 1);
    hold = 1'b0; cyc(30);
    chk(log_n == 3, "R8 queued steps drained", log_n, 3);
    chk({step_log[0], step_log[1], step_log[2]} == 3'b101,
        "R8 issue order advance,retard,advance",
        {step_log[0], step_log[1], step_log[2]}, 5);
  endtask

  task automatic t_queue_full;
    do_reset(0, 0, 0, 0);
    hold = 1'b1;
    drive(1, 0, 1, 6 * 64); cyc(10);
    hold = 1'b0; cyc(60);
    chk(log_n == 5, "R8 one issued plus four held, excess dropped", log_n, 5);
  endtask

  task automatic t_reset_clears;
    do_reset(0, 0, -262144, 262144);
    hold = 1'b1;
    drive(1, 0, 1, 200); cyc(50);
    do_reset(0, 0, -262144, 262144);
    cyc(200);
    chk(log_n == 0, "R9 reset discards queue and integrator", log_n, 0);
  endtask

  initial begin
    #(20ns * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_prop_late();
    t_prop_early();
    t_no_decision();
    t_integral_rate();
    t_saturation();
    t_handshake();
    t_order();
    t_queue_full();
    t_reset_clears();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule